// File: doc/BRIEF.md
# Pipelined Eight-Byte CRC-16 Generator

This block computes a 16-bit cyclic redundancy check (generator x^16 + x^12 + x^5 + 1, value 0x1021) over a message that arrives as 64-bit beats. Each beat carries eight bytes. A beat is taken on every clock edge where `in_valid` is high, and `in_last` marks the closing beat of a message. Every message is a whole number of beats. The check value starts from zero. No bit reflection is applied, bits are taken most significant first within each byte, and no final inversion is made.

The datapath has three register stages. The first stage does the per-byte work. Seven byte positions each go through an elaboration-time table. That table gives the byte's remainder after it has been moved past all the later bytes of the beat. The latest byte needs no table, because a value narrower than the generator is already its own remainder. The first stage then XORs the eight contributions together and registers the result.

The second stage keeps a running remainder. On each beat it folds the previous remainder forward by one beat width through a further table, then XORs in the registered contribution. The third stage multiplies the closing remainder by x^16 through a final table. It presents the check value together with a one-cycle done strobe.

Top module: `crc16_pipe`

## Requirements
- R1: `crc_out` equals the CRC of the message bytes taken in order: polynomial 0x1021, initial value 0x0000, most significant bit of each byte first, no reflection and no final XOR.
- R2: Byte lane i is `in_data[8*i+7:8*i]`. Lane 0 is the earliest byte of a beat and lane 7 the latest. A beat whose only non-zero byte is 0x01 in lane 7 gives 0x1021.
- R3: A message may span 1 to 16 beats, and the running remainder carries across every beat of the message.
- R4: If the closing beat is taken at clock edge k, `crc_valid` is high, and `crc_out` holds that message's check value, in the cycle after edge k+2. `crc_valid` is high in no other cycle, so there is exactly one pulse per message.
- R5: Each message starts from a zero remainder, even when its first beat directly follows the closing beat of the previous message.
- R6: Cycles with `in_valid` low between the beats of a message leave the result unchanged.
- R7: `in_data` and `in_last` have no effect while `in_valid` is low.
- R8: While `rst_n` is low, `crc_valid` and `crc_out` are zero, and any partly received message is discarded.
- R9: `crc_out` keeps its last value until the next message completes.
- R10: A message made entirely of zero bytes gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A beat is present on `in_data` |
| in_last | input | 1 | The current beat closes its message |
| in_data | input | 64 | Eight bytes, lane 0 in the low byte is the earliest |
| crc_out | output | 16 | Check value of the most recently completed message |
| crc_valid | output | 1 | One-cycle strobe: `crc_out` was just updated |

## Verification
The assertions assume that `in_last` is only meaningful together with `in_valid`. They also assume that a message is never shorter than one beat, so that every closing beat is a real beat of its message. The stimulus raises `in_last` only on the final beat of each generated message. During idle gaps it drives deliberately misleading `in_data` and `in_last` values with `in_valid` low, which exercises R7 without breaking the first assumption. Reset is applied both at the start and in the middle of a message. No message is left unterminated outside a reset.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam int          CRC_W    = 16;

  // Multiply a remainder by x^nbits modulo the generator (feed nbits zero bits).
  function automatic logic [15:0] crc_zstep(input logic [15:0] r, input int nbits);
    logic [15:0] t;
    t = r;
    for (int s = 0; s < nbits; s++) begin
      t = t[15] ? ((t << 1) ^ CRC_POLY) : (t << 1);
    end
    return t;
  endfunction

  // Table entry: byte idx placed in the high or low half, then shifted nbits.
  function automatic logic [15:0] lut_entry(input int idx, input int hi, input int nbits);
    logic [15:0] r;
    r = (hi != 0) ? {idx[7:0], 8'h00} : {8'h00, idx[7:0]};
    return crc_zstep(r, nbits);
  endfunction

endpackage

// File: rtl/crc16_byte_lut.sv
module crc16_byte_lut #(
  parameter int ZBITS = 8,
  parameter int HI    = 0
) (
  input  logic [7:0]  idx,
  output logic [15:0] val
);
  logic [15:0] tbl [256];

  for (genvar j = 0; j < 256; j++) begin : g_ent
    localparam logic [15:0] ENT = crc16_pkg::lut_entry(j, HI, ZBITS);
    assign tbl[j] = ENT;
  end

  assign val = tbl[idx];
endmodule

// File: rtl/crc16_pre_stage.sv
module crc16_pre_stage #(
  parameter int LANES = 8,
  localparam int DW   = 8 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  output logic          v1,
  output logic          last1,
  output logic [15:0]   pre_q
);
  logic [15:0] lane_val [LANES];
  logic [15:0] lane_sum;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == LANES - 1) begin : g_tail
      // latest byte: already narrower than the generator, no table
      assign lane_val[i] = {8'h00, in_data[8*i +: 8]};
    end else begin : g_tab
      crc16_byte_lut #(.ZBITS(8 * (LANES - 1 - i)), .HI(0)) u_lut (
        .idx (in_data[8*i +: 8]),
        .val (lane_val[i])
      );
    end
  end

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < LANES; i++) lane_sum = lane_sum ^ lane_val[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      last1 <= 1'b0;
      pre_q <= '0;
    end else begin
      v1    <= in_valid;
      last1 <= in_valid && in_last;
      if (in_valid) pre_q <= lane_sum;
    end
  end
endmodule

// File: rtl/crc16_run_state.sv
module crc16_run_state #(
  parameter int LANES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        v1,
  input  logic        last1,
  input  logic [15:0] pre_q,
  output logic [15:0] run_crc,
  output logic        fin_pend
);
  logic [15:0] fold_hi, fold_lo, carry;
  logic        mid_msg;
  logic        beat_close;

  crc16_byte_lut #(.ZBITS(8 * LANES), .HI(1)) u_fold_hi (
    .idx (run_crc[15:8]), .val (fold_hi));
  crc16_byte_lut #(.ZBITS(8 * LANES), .HI(0)) u_fold_lo (
    .idx (run_crc[7:0]),  .val (fold_lo));

  assign beat_close = v1 && last1;
  assign carry      = mid_msg ? (fold_hi ^ fold_lo) : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_crc  <= '0;
      mid_msg  <= 1'b0;
      fin_pend <= 1'b0;
    end else begin
      fin_pend <= beat_close;
      if (v1) begin
        run_crc <= pre_q ^ carry;
        mid_msg <= !last1;
      end
    end
  end

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(run_crc));                                          // R6
  AST_LAST_CLOSES_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    beat_close |=> !mid_msg);                                           // R5
  AST_FIN_FROM_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_pend |-> $past(v1 && last1));                                   // R4
endmodule

// File: rtl/crc16_pipe.sv
module crc16_pipe #(
  parameter int LANES = 8,
  localparam int DW   = 8 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  output logic [15:0]   crc_out,
  output logic          crc_valid
);
  logic        v1, last1, fin_pend;
  logic [15:0] pre_q, run_crc, fin_hi, fin_lo;

  crc16_pre_stage #(.LANES(LANES)) u_pre (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_last (in_last),
    .in_data (in_data), .v1 (v1), .last1 (last1), .pre_q (pre_q));

  crc16_run_state #(.LANES(LANES)) u_state (
    .clk (clk), .rst_n (rst_n), .v1 (v1), .last1 (last1), .pre_q (pre_q),
    .run_crc (run_crc), .fin_pend (fin_pend));

  // closing remainder times x^16 gives the transmitted check value
  crc16_byte_lut #(.ZBITS(crc16_pkg::CRC_W), .HI(1)) u_fin_hi (
    .idx (run_crc[15:8]), .val (fin_hi));
  crc16_byte_lut #(.ZBITS(crc16_pkg::CRC_W), .HI(0)) u_fin_lo (
    .idx (run_crc[7:0]),  .val (fin_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_out   <= '0;
      crc_valid <= 1'b0;
    end else begin
      crc_valid <= fin_pend;
      if (fin_pend) crc_out <= fin_hi ^ fin_lo;
    end
  end

  AST_VALID_FOLLOWS_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin_pend |=> crc_valid);                                            // R4
  AST_VALID_NEEDS_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> $past(fin_pend));                                     // R4
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_pend |=> $stable(crc_out));                                    // R9
endmodule

// File: tb/tb_crc16_pipe.sv
module tb_crc16_pipe;
  localparam int LANES = 8;
  localparam int DW    = 8 * LANES;
  localparam int MAXB  = 16;
  localparam int VEC_N = 10;
  localparam int VEC_BEATS [VEC_N] = '{1, 2, 3, 16, 5, 8, 1, 13, 4, 7};
  localparam int VEC_SEED  [VEC_N] = '{11, 29, 305, 4711, 77, 9001, 3, 123457, 64, 8080};
  localparam bit VEC_GAP   [VEC_N] = '{0, 0, 1, 0, 1, 0, 0, 1, 0, 1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [15:0]   crc_out;
  logic          crc_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0]  msg [MAXB*LANES];
  logic [15:0] expq [$];
  logic [2:0]  hist;
  int unsigned lcg;

  always #2 clk = ~clk;

  crc16_pipe #(.LANES(LANES)) dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_last (in_last),
    .in_data (in_data), .crc_out (crc_out), .crc_valid (crc_valid));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit-serial reference: shift each message bit in, MSB first
  function automatic logic [15:0] ref_crc(input int nbytes);
    logic [15:0] c;
    logic        fb;
    c = 16'h0000;
    for (int n = 0; n < nbytes; n++)
      for (int b = 7; b >= 0; b--) begin
        fb = c[15] ^ msg[n][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  function automatic logic [7:0] next_rand();
    lcg = lcg * 1103515245 + 12345;
    return lcg[23:16];
  endfunction

  task automatic fill(input int seed, input int nbeats);
    lcg = seed;
    for (int n = 0; n < nbeats * LANES; n++) msg[n] = next_rand();
  endtask

  task automatic send(input int nbeats, input bit gap);
    logic [15:0] e;
    e = ref_crc(nbeats * LANES);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_last  = (b == nbeats - 1);
      for (int i = 0; i < LANES; i++) in_data[8*i +: 8] = msg[b*LANES + i];
      if (b == nbeats - 1) expq.push_back(e);
      if (gap && b != nbeats - 1) begin
        @(negedge clk);
        in_valid = 1'b0;        // R7: misleading values while not valid
        in_last  = 1'b1;
        for (int i = 0; i < LANES; i++) in_data[8*i +: 8] = next_rand();
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b1;
      in_data  = {DW{1'b1}};
    end
  endtask

  // expected done history: closing beat taken at edge k -> valid after edge k+2
  always @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[1:0], in_valid && in_last};
  end

  always @(negedge clk) begin
    if (rst_n && (crc_valid || hist[2])) begin
      chk(crc_valid === hist[2], "R4 done strobe", int'(crc_valid), int'(hist[2]));
      if (crc_valid && hist[2]) begin
        if (expq.size() == 0) chk(1'b0, "R4 unexpected result", int'(crc_out), 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(crc_out === e, "R1 R3 check value", int'(crc_out), int'(e));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(crc_valid === 1'b0, "R8 reset valid", int'(crc_valid), 0);
    chk(crc_out === 16'h0, "R8 reset value", int'(crc_out), 0);
    rst_n = 1'b1;

    // table walk: lengths, seeds and gap pattern
    for (int v = 0; v < VEC_N; v++) begin
      fill(VEC_SEED[v], VEC_BEATS[v]);
      send(VEC_BEATS[v], VEC_GAP[v]);   // R3 R5 R6 R7
    end
    idle(6);

    // R10: all-zero message
    for (int n = 0; n < 2 * LANES; n++) msg[n] = 8'h00;
    send(2, 1'b0);
    idle(5);
    chk(crc_out === 16'h0000, "R10 zero message", int'(crc_out), 0);

    // R2: 0x01 in lane 7 only
    for (int n = 0; n < LANES; n++) msg[n] = 8'h00;
    msg[LANES-1] = 8'h01;
    send(1, 1'b0);
    idle(5);
    chk(crc_out === 16'h1021, "R2 latest lane", int'(crc_out), 16'h1021);
    idle(4);
    chk(crc_out === 16'h1021, "R9 value held", int'(crc_out), 16'h1021);

    // R2: 0x01 in lane 0 only, must differ from the lane 7 result
    msg[LANES-1] = 8'h00;
    msg[0] = 8'h01;
    send(1, 1'b0);
    idle(5);
    chk(crc_out !== 16'h1021, "R2 earliest lane", int'(crc_out), int'(ref_crc(LANES)));

    // R5: back-to-back single-beat messages, a done strobe every cycle
    for (int m = 0; m < 6; m++) begin
      fill(500 + m, 1);
      send(1, 1'b0);
    end
    // R5: multi-beat messages back to back
    fill(42, 3);  send(3, 1'b0);
    fill(43, 16); send(16, 1'b0);
    fill(44, 2);  send(2, 1'b0);
    idle(6);

    // R8: reset in the middle of a message discards it
    fill(900, 4);
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_last  = 1'b0;
      for (int i = 0; i < LANES; i++) in_data[8*i +: 8] = msg[b*LANES + i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(crc_valid === 1'b0, "R8 mid reset valid", int'(crc_valid), 0);
    chk(crc_out === 16'h0, "R8 mid reset value", int'(crc_out), 0);
    rst_n = 1'b1;
    fill(901, 2);
    send(2, 1'b0);
    idle(8);

    chk(expq.size() == 0, "R4 missing results", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule